// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block collects up to eight interrupt request lines that arrive from outside the chip and turns them into interrupt outputs. Each line is synchronised to the block clock. Its trigger condition is then evaluated: falling edge, rising edge, either edge, low level or high level. A hit is latched into a pending flag. The pending flag reaches a per-line output only when the line is unmasked and its priority field is non-zero. All per-line outputs are also ORed into one combined output.

Software reaches the block through a simple register bus with five word addresses. Two of them are read-write configuration words: one holds the trigger code for every line and the other holds the priority field for every line. The source word shows the pending flags, and writing a zero bit to it clears the matching flag. The last two words are write-only. Writing a one bit to the first masks the matching line, and writing a one bit to the second unmasks it. Reads take effect in the same cycle. Writes take effect on the next clock edge.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the trigger word, the priority word and the source word all read zero, every line is masked, and `irq_pin` and `irq_any` are low.
- R2: The trigger word (address 0) holds a SENSE_W-bit field for line n at bits [31-n*SENSE_W -: SENSE_W]. The priority word (address 1) holds a 4-bit field for line n at bits [31-4n -: 4]. Both words read back what was last written, and bits not assigned to any line read zero.
- R3: Trigger codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 both edges. A written field whose value is above 4 is discarded: that line keeps its previous code, while the other fields in the same write still update.
- R4: In an edge mode the pending flag of a line sets on the selected transition of the synchronised input. Pending flags read at source-word (address 2) bit SRC_W-1-n, so line 0 is the most significant used bit.
- R5: In a level mode the pending flag is set on every cycle in which the synchronised input is at the active level, so a clear issued while the level persists does not stick.
- R6: A write to the source word clears the pending flag of line n when bit SRC_W-1-n of the write data is 0. A 1 bit leaves that flag unchanged.
- R7: A write to address 3 masks line n when bit SRC_W-1-n is 1. A 0 bit leaves the mask state unchanged. The address reads zero.
- R8: A write to address 4 unmasks line n when bit SRC_W-1-n is 1. A 0 bit leaves the mask state unchanged. The address reads zero.
- R9: A line whose priority field is zero gives no output. Any non-zero field enables it.
- R10: `irq_pin[n]` is high exactly when line n is pending, unmasked and has a non-zero priority. `irq_any` is the OR of all `irq_pin` bits.
- R11: If a trigger event and a software clear of the same line fall in the same cycle, the pending flag stays set.
- R12: A change applied to `pin_in` before clock edge k reaches the pending flag, the source word and the outputs on edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_PINS | Asynchronous external interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address: 0 trigger, 1 priority, 2 source, 3 mask set, 4 mask clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_pin | output | NUM_PINS | Per-line interrupt outputs |
| irq_any | output | 1 | OR of all per-line outputs |

## Verification
The bench builds the block with NUM_PINS=8, SENSE_W=4 and SRC_W=8. The 4-bit trigger fields make the both-edge code and the out-of-range codes 5 to 15 reachable. The 8-bit source width checks that the most-significant-first bit order lands on bits 7 down to 0 rather than on the top of the word. With all eight lines present, a write that mixes valid and invalid codes in neighbouring fields can be seen to update the valid fields while discarding the invalid ones.

// File: rtl/eirq_pkg.sv
// Shared definitions for the external interrupt pin controller.
// Assumes 32-bit register words and a 3-bit word address.
package eirq_pkg;
    localparam int REG_W  = 32;
    localparam int PRIO_W = 4;

    typedef enum logic [2:0] {
        ADR_TRIG = 3'd0,
        ADR_PRIO = 3'd1,
        ADR_SRC  = 3'd2,
        ADR_MSET = 3'd3,
        ADR_MCLR = 3'd4
    } eirq_addr_e;

    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } eirq_trig_e;
endpackage

// File: rtl/eirq_sync.sv
// Two-flop synchroniser for each external line.
// Assumes the lines are asynchronous level signals. Output lags the input by two edges.
module eirq_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] stab_q;

    // Capture the raw lines, then retime them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= pin_async;
            stab_q <= meta_q;
        end
    end

    assign pin_sync = stab_q;
endmodule

// File: rtl/eirq_detect.sv
// Trigger evaluation for each line: compares the synchronised level with its
// previous value and raises a one-cycle (edge) or continuous (level) event.
// Assumes trigger codes have already been validated by the register file.
module eirq_detect #(
    parameter int NUM_PINS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0]      pin_sync,
    input  logic [NUM_PINS-1:0][2:0] trig,
    output logic [NUM_PINS-1:0]      evt
);
    import eirq_pkg::*;

    logic [NUM_PINS-1:0] hist_q;

    // Remember last cycle's synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= pin_sync;
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        // Decode the trigger condition for this line.
        always_comb begin
            case (trig[n])
                TRIG_FALL: evt[n] = hist_q[n] & ~pin_sync[n];
                TRIG_RISE: evt[n] = ~hist_q[n] & pin_sync[n];
                TRIG_LOW:  evt[n] = ~pin_sync[n];
                TRIG_HIGH: evt[n] = pin_sync[n];
                TRIG_BOTH: evt[n] = hist_q[n] ^ pin_sync[n];
                default:   evt[n] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/eirq_regs.sv
// Register file and per-line state: trigger word, priority word, pending flags and mask bits.
// Assumes NUM_PINS <= 8, NUM_PINS*SENSE_W <= 32 and NUM_PINS <= SRC_W <= 32.
module eirq_regs #(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [2:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_PINS-1:0]      evt,
    output logic [NUM_PINS-1:0][2:0] trig,
    output logic [NUM_PINS-1:0]      prio_en,
    output logic [NUM_PINS-1:0]      mask,
    output logic [NUM_PINS-1:0]      pend
);
    import eirq_pkg::*;

    localparam logic [REG_W-1:0] ONES      = {REG_W{1'b1}};
    localparam logic [REG_W-1:0] TRIG_USED = ~(ONES >> (NUM_PINS*SENSE_W));
    localparam logic [REG_W-1:0] PRIO_USED = ~(ONES >> (NUM_PINS*PRIO_W));

    logic [REG_W-1:0]    trig_q;
    logic [REG_W-1:0]    prio_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] fld_ok;
    logic [NUM_PINS-1:0] clr_req;

    logic wr_trig, wr_prio, wr_src, wr_mset, wr_mclr;

    // Decode the write strobes per address.
    always_comb begin
        wr_trig = bus_sel && bus_wr && (bus_addr == ADR_TRIG);
        wr_prio = bus_sel && bus_wr && (bus_addr == ADR_PRIO);
        wr_src  = bus_sel && bus_wr && (bus_addr == ADR_SRC);
        wr_mset = bus_sel && bus_wr && (bus_addr == ADR_MSET);
        wr_mclr = bus_sel && bus_wr && (bus_addr == ADR_MCLR);
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int FHI = REG_W - 1 - n*SENSE_W;
        localparam int PHI = REG_W - 1 - n*PRIO_W;
        localparam int SB  = SRC_W - 1 - n;

        // Validate the trigger code offered for this line.
        if (SENSE_W >= 3) begin : g_chk
            always_comb fld_ok[n] = (bus_wdata[FHI -: SENSE_W] <= SENSE_W'(4));
        end else begin : g_nochk
            always_comb fld_ok[n] = 1'b1;
        end

        // Present decoded per-line configuration and state.
        always_comb begin
            trig[n]    = 3'(trig_q[FHI -: SENSE_W]);
            prio_en[n] = |prio_q[PHI -: PRIO_W];
            clr_req[n] = wr_src && !bus_wdata[SB];
        end

        // Pending flag: a new event beats a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[n] <= 1'b0;
            else        pend_q[n] <= evt[n] | (pend_q[n] & ~clr_req[n]);
        end

        // Mask bit: set and clear come through separate addresses.
        always_ff @(posedge clk) begin
            if (!rst_n)                        mask_q[n] <= 1'b1;
            else if (wr_mset && bus_wdata[SB]) mask_q[n] <= 1'b1;
            else if (wr_mclr && bus_wdata[SB]) mask_q[n] <= 1'b0;
        end

        a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt[n] |=> pend_q[n]);
        a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_src && !bus_wdata[SB] && !evt[n]) |=> !pend_q[n]);
        a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_src && bus_wdata[SB] && pend_q[n]) |=> pend_q[n]);
        a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mset && bus_wdata[SB]) |=> mask_q[n]);
        a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mclr && bus_wdata[SB]) |=> !mask_q[n]);
        a_r3_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_trig && !fld_ok[n]) |=> $stable(trig_q[FHI -: SENSE_W]));
    end

    // Trigger word: accept only the fields carrying a valid code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (wr_trig) begin
            for (int n = 0; n < NUM_PINS; n++) begin
                if (fld_ok[n])
                    trig_q[REG_W-1-n*SENSE_W -: SENSE_W] <= bus_wdata[REG_W-1-n*SENSE_W -: SENSE_W];
            end
        end
    end

    // Priority word: store the fields that belong to a line.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= '0;
        else if (wr_prio) prio_q <= bus_wdata & PRIO_USED;
    end

    // Read multiplexer; the mask addresses are write-only.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADR_TRIG: bus_rdata = trig_q & TRIG_USED;
                ADR_PRIO: bus_rdata = prio_q;
                ADR_SRC: begin
                    for (int n = 0; n < NUM_PINS; n++)
                        bus_rdata[SRC_W-1-n] = pend_q[n];
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign mask = mask_q;
    assign pend = pend_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
// External interrupt pin controller top: synchroniser, trigger detection and register file.
// Assumes every pin_in line is asynchronous to clk. Outputs are combinational from state registers.
module ext_irq_ctrl #(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_pin,
    output logic                irq_any
);
    logic [NUM_PINS-1:0]      pin_sync;
    logic [NUM_PINS-1:0]      evt;
    logic [NUM_PINS-1:0][2:0] trig;
    logic [NUM_PINS-1:0]      prio_en;
    logic [NUM_PINS-1:0]      mask;
    logic [NUM_PINS-1:0]      pend;

    eirq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync)
    );

    eirq_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .trig(trig), .evt(evt)
    );

    eirq_regs #(.NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W), .SRC_W(SRC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt(evt), .trig(trig), .prio_en(prio_en), .mask(mask), .pend(pend)
    );

    // Gate each pending flag with its mask and priority enable, then combine.
    always_comb begin
        irq_pin = pend & ~mask & prio_en;
        irq_any = |irq_pin;
    end

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> !irq_any);
    a_r9_prio_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_en == '0) |-> (irq_pin == '0));
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
    localparam int PERIOD = 10;
    localparam int NP = 8;
    localparam int SW = 4;
    localparam int SRCW = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic [NP-1:0] pin_in = '0;
    logic bus_sel = 0, bus_wr = 0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] irq_pin;
    logic irq_any;

    int checks = 0, errors = 0;
    bit done = 0;

    ext_irq_ctrl #(.NUM_PINS(NP), .SENSE_W(SW), .SRC_W(SRCW)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .irq_any(irq_any)
    );

    always #(PERIOD/2) clk = ~clk;

    // Behavioural reference state
    bit m_d1[NP], m_d2[NP], m_old[NP], m_pend[NP], m_mask[NP];
    int m_trig[NP], m_prio[NP];

    always @(posedge clk) begin
        bit ev[NP];
        bit clr[NP];
        if (!rst_n) begin
            for (int n = 0; n < NP; n++) begin
                m_d1[n] = 0; m_d2[n] = 0; m_old[n] = 0; m_pend[n] = 0;
                m_mask[n] = 1; m_trig[n] = 0; m_prio[n] = 0;
            end
        end else begin
            for (int n = 0; n < NP; n++) begin
                case (m_trig[n])
                    0: ev[n] = m_old[n] && !m_d2[n];
                    1: ev[n] = !m_old[n] && m_d2[n];
                    2: ev[n] = !m_d2[n];
                    3: ev[n] = m_d2[n];
                    4: ev[n] = m_old[n] != m_d2[n];
                    default: ev[n] = 0;
                endcase
                clr[n] = 0;
            end
            if (bus_sel && bus_wr) begin
                for (int n = 0; n < NP; n++) begin
                    int f;
                    bit b;
                    b = bus_wdata[SRCW-1-n];
                    case (bus_addr)
                        3'd0: begin
                            f = int'((bus_wdata >> (28 - 4*n)) & 32'hF);
                            if (f <= 4) m_trig[n] = f;
                        end
                        3'd1: m_prio[n] = int'((bus_wdata >> (28 - 4*n)) & 32'hF);
                        3'd2: clr[n] = !b;
                        3'd3: if (b) m_mask[n] = 1;
                        3'd4: if (b) m_mask[n] = 0;
                        default: ;
                    endcase
                end
            end
            for (int n = 0; n < NP; n++) begin
                m_pend[n] = ev[n] || (m_pend[n] && !clr[n]);
                m_old[n] = m_d2[n];
                m_d2[n] = m_d1[n];
                m_d1[n] = pin_in[n];
            end
        end
    end

    function automatic logic [NP-1:0] exp_irq();
        logic [NP-1:0] r;
        for (int n = 0; n < NP; n++) r[n] = m_pend[n] && !m_mask[n] && (m_prio[n] != 0);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] r = '0;
        for (int n = 0; n < NP; n++) begin
            case (a)
                3'd0: r |= 32'(m_trig[n]) << (28 - 4*n);
                3'd1: r |= 32'(m_prio[n]) << (28 - 4*n);
                3'd2: r[SRCW-1-n] = m_pend[n];
                default: ;
            endcase
        end
        return r;
    endfunction

    // Per-cycle comparison of the interrupt outputs (R10, R12)
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            checks++;
            if (irq_pin !== exp_irq() || irq_any !== (|exp_irq())) begin
                errors++;
                $display("FAIL R10 irq_pin=%b irq_any=%b expected %b %b",
                         irq_pin, irq_any, exp_irq(), |exp_irq());
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_check(input logic [2:0] a, input string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp_read(a)) begin
            errors++;
            $display("FAIL %s addr %0d read %h expected %h", req, a, bus_rdata, exp_read(a));
        end
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic check_val(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        bus_check(3'd0, "R1");
        bus_check(3'd1, "R1");
        bus_check(3'd2, "R1");
        check_val({31'd0, irq_any}, 32'd0, "R1 irq_any");
        bus_check(3'd3, "R7 write-only reads zero");

        // Idle levels: pin1 (falling) and pin2 (low level) rest high
        @(negedge clk); pin_in = 8'b0000_0110;
        idle(4);
        // R9/R8: enable priorities, unmask all
        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_write(3'd4, 32'h0000_00FF);
        // R2/R3: codes pin0 rise, pin1 fall, pin2 low, pin3 high, pin4 both, rest rise
        bus_write(3'd0, 32'h1023_4111);
        bus_check(3'd0, "R2");
        bus_check(3'd1, "R2");
        bus_write(3'd2, 32'h0);
        bus_check(3'd2, "R6");

        // R12: latency of a rising edge on pin0
        @(negedge clk); pin_in[0] = 1;
        @(posedge clk); #2 check_val({31'd0, irq_pin[0]}, 0, "R12 edge k");
        @(posedge clk); #2 check_val({31'd0, irq_pin[0]}, 0, "R12 edge k+1");
        @(posedge clk); #2 check_val({31'd0, irq_pin[0]}, 1, "R12 edge k+2");
        bus_check(3'd2, "R4 MSB-first source");

        // R4: falling on pin1, both edges on pin4
        @(negedge clk); pin_in[1] = 0; pin_in[4] = 1;
        idle(4);
        @(negedge clk); pin_in[4] = 0;
        idle(4);
        bus_check(3'd2, "R4");
        // R6: clear only pin4 (bit 3)
        bus_write(3'd2, 32'hFFFF_FFF7);
        bus_check(3'd2, "R6 single clear");

        // R5: level low on pin2, clear while active does not stick
        @(negedge clk); pin_in[2] = 0;
        idle(4);
        bus_write(3'd2, 32'h0);
        bus_check(3'd2, "R5 level persists");
        @(negedge clk); pin_in[2] = 1;
        idle(4);
        bus_write(3'd2, 32'h0);
        bus_check(3'd2, "R5 cleared after release");

        // R3: invalid code on pin5 (7), valid code on pin6 (2)
        bus_write(3'd0, 32'h1023_4721);
        bus_check(3'd0, "R3");

        // R7: mask pin0 via set register; zero bits elsewhere unchanged
        bus_write(3'd3, 32'h0000_0080);
        @(negedge clk); pin_in[0] = 0;
        idle(2);
        @(negedge clk); pin_in[0] = 1;
        idle(4);
        check_val({31'd0, irq_pin[0]}, 0, "R7 masked output");
        bus_check(3'd2, "R7 pending while masked");
        // R8: unmask shows it
        bus_write(3'd4, 32'h0000_0080);
        idle(1);
        check_val({31'd0, irq_pin[0]}, 1, "R8 unmasked output");

        // R9: priority zero on pin0 only
        bus_write(3'd1, 32'h0FFF_FFFF);
        idle(1);
        check_val({31'd0, irq_pin[0]}, 0, "R9 prio zero");
        bus_write(3'd1, 32'h3FFF_FFFF);
        idle(1);
        check_val({31'd0, irq_pin[0]}, 1, "R9 prio nonzero");
        bus_write(3'd2, 32'h0);

        // R11: edge event on pin7 in the same cycle as clear-all
        @(negedge clk); pin_in[7] = 1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'h0;
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        check_val({31'd0, irq_pin[7]}, 1, "R11 edge wins");
        bus_check(3'd2, "R11");

        // Mixed random activity, compared each cycle (R10)
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            pin_in = 8'($urandom);
            if (i % 7 == 0) begin
                bus_sel = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'($urandom);
            end else if (i % 11 == 0) begin
                bus_sel = 1; bus_wr = 1; bus_addr = 3'(3 + ($urandom % 2)); bus_wdata = 32'($urandom);
            end else if (i % 29 == 0) begin
                bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'($urandom);
            end else begin
                bus_sel = 0; bus_wr = 0;
            end
        end
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        bus_check(3'd0, "R3 after random");
        bus_check(3'd2, "R4 after random");
        idle(2);
        finish_run();
    end
endmodule